// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Locks and RAM Mode

This block sits between a fetch requester and a slower backing-memory read port. Every fetch carries a word address, an instruction/data flag and a region flag. The address is split from the top down into a tag, a set index and a word offset. The block compares the tag against both ways of the indexed set. On a hit it returns the word in the following cycle. On a miss it reads the whole four-word line from backing memory, one word per beat, and then returns the requested word. Each set keeps a record of its most recently used way, and the replacement choice comes from that record.

Three controls change how the block behaves. An update lock keeps hits working but stops misses from allocating lines. A sticky read lock hides the tag, valid and MRU debug view, and only reset removes it. A RAM mode turns the data array into plain read/write memory on its own port and sends every fetch uncached to backing memory. Entering RAM mode zeroes the data array. Leaving it invalidates every line. Neither lock has any effect while RAM mode is active.

Top module: `sa_read_cache`

## Requirements
- R1: A fetch whose tag matches a valid way of its set is a hit. rsp_valid rises with rsp_hit=1 and the stored word in the cycle after acceptance, and no backing read is issued.
- R2: A fetch that misses holds req_ready low and reads the four words of its line from backing memory, offsets 0 to 3 in order. It then returns the requested word with rsp_hit=0.
- R3: A completed fill writes the tag, sets the way valid and makes that way the set's MRU way (dbg_mru: 0 = way 0, 1 = way 1). A hit makes the hit way the MRU way.
- R4: On a miss, the victim is the first invalid way (way 0 before way 1). If both ways are valid, the victim is the way that is not the MRU way.
- R5: With cfg_upd_lock high and RAM mode off, a miss is still fetched and returned, but no line is allocated or invalidated. Hits are still served from the existing contents.
- R6: After cfg_rd_lock is high on a clock edge, dbg_tag, dbg_valid and dbg_mru read as zero outside RAM mode. This lasts until rst_n is asserted.
- R7: In RAM mode, fetches always go to backing memory, return rsp_hit=0 and allocate nothing. The data array is read and written through the ram_* port: a write takes effect on the clock edge, and a read returns its data one cycle later. ram_addr holds the way in its top bit, then the set index, then the word offset in the low bits.
- R8: Entering RAM mode clears every word of the data array to zero.
- R9: Leaving RAM mode invalidates every line, so the next fetch of a previously cached line misses.
- R10: While RAM mode is active the read lock has no effect, and the debug outputs show the stored tag, valid bit and MRU way.
- R11: Outside RAM mode the ram_* port is ignored: writes do not alter cached data and ram_rdata reads as zero.
- R12: After reset: req_ready=1, rsp_valid=0, mem_req=0, every line is invalid and every MRU way is 0.
- R13: During every backing-memory beat, mem_instr and mem_region equal the flags of the fetch that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block can accept a fetch |
| req_addr | input | ADDR_W | Word address of the fetch |
| req_instr | input | 1 | Instruction (1) or data (0) fetch |
| req_region | input | 1 | Region selector of the fetch |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Returned word |
| rsp_hit | output | 1 | Response was served from the cache |
| mem_req | output | 1 | Backing read beat request |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_instr | output | 1 | Instruction flag forwarded with the beat |
| mem_region | output | 1 | Region flag forwarded with the beat |
| mem_rvalid | input | 1 | Backing read data valid |
| mem_rdata | input | DATA_W | Backing read data |
| cfg_upd_lock | input | 1 | Stop allocation on misses |
| cfg_ram_mode | input | 1 | Use the data array as plain RAM |
| cfg_rd_lock | input | 1 | Set the sticky debug read lock |
| ram_en | input | 1 | RAM-port access enable |
| ram_we | input | 1 | RAM-port write (1) or read (0) |
| ram_addr | input | 1+log2(SETS)+log2(WORDS) | {way, set, word} of the RAM access |
| ram_wdata | input | DATA_W | RAM-port write data |
| ram_rdata | output | DATA_W | RAM-port read data, one cycle later |
| dbg_set | input | log2(SETS) | Debug set select |
| dbg_way | input | 1 | Debug way select |
| dbg_tag | output | ADDR_W-log2(SETS)-log2(WORDS) | Tag of the selected way |
| dbg_valid | output | 1 | Valid bit of the selected way |
| dbg_mru | output | 1 | MRU way of the selected set |

## Verification
The hardest state to reach is a set with both ways valid whose MRU way has been flipped by a hit between two fills. Only there does the non-MRU victim rule differ from the invalid-first rule. The stimulus table therefore interleaves hits and misses to three tags of one set, and the debug view confirms each eviction. A second hard case is the invalidation on leaving RAM mode while the read lock hides the debug view. It is shown through the fetch port: the bench changes the backing-memory contents and expects misses that return the new data.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} fill_st_t;

  // Replacement: first invalid way, else the way other than the MRU one.
  function automatic logic pick_victim(input logic v0, input logic v1, input logic mru);
    if (!v0) return 1'b0;
    if (!v1) return 1'b1;
    return ~mru;
  endfunction
endpackage

// File: rtl/sarc_tag_store.sv
module sarc_tag_store
  import sarc_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 11,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  lk_hit,
  output logic [WAYS-1:0]  lk_vld,
  output logic             lk_mru,
  input  logic             fill_start,
  input  logic             fill_end,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             touch,
  input  logic             touch_way,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] dbg_idx,
  input  logic             dbg_way,
  input  logic             dbg_hide,
  output logic [TAG_W-1:0] dbg_tag,
  output logic             dbg_valid,
  output logic             dbg_mru,
  output logic             any_valid
);
  logic [WAYS-1:0][TAG_W-1:0] way_dtag;
  logic [WAYS-1:0]            way_dvld;
  logic [WAYS-1:0]            way_any;
  logic [SETS-1:0]            mru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic             sel;

    assign sel         = (wr_way == 1'(w));
    assign lk_vld[w]   = vld_q[lk_idx];
    assign lk_hit[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign way_dtag[w] = tag_q[dbg_idx];
    assign way_dvld[w] = vld_q[dbg_idx];
    assign way_any[w]  = |vld_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
      end else if (inv_all) begin
        vld_q <= '0;
      end else begin
        if (fill_start && sel) vld_q[wr_idx] <= 1'b0;
        if (fill_end && sel) begin
          vld_q[wr_idx] <= 1'b1;
          tag_q[wr_idx] <= wr_tag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mru_q <= '0;
    else if (fill_end) mru_q[wr_idx] <= wr_way;
    else if (touch)    mru_q[lk_idx] <= touch_way;
  end

  assign lk_mru    = mru_q[lk_idx];
  assign any_valid = |way_any;
  assign dbg_tag   = dbg_hide ? '0   : way_dtag[dbg_way];
  assign dbg_valid = dbg_hide ? 1'b0 : way_dvld[dbg_way];
  assign dbg_mru   = dbg_hide ? 1'b0 : mru_q[dbg_idx];
endmodule

// File: rtl/sarc_data_store.sv
module sarc_data_store #(
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int DEPTH = 2 * SETS * WORDS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              clr_all,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (clr_all) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
  import sarc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int AW    = 1 + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_instr,
  input  logic              req_region,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_instr,
  output logic              mem_region,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ram_active,
  input  logic              upd_lock,
  input  logic [WAYS-1:0]   lk_hit,
  input  logic [WAYS-1:0]   lk_vld,
  input  logic              lk_mru,
  input  logic [DATA_W-1:0] hit_rdata,
  output logic              req_fire,
  output logic              lookup_hit,
  output logic              hit_way,
  output logic              fill_start,
  output logic              fill_end,
  output logic              fill_way,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              fwr_en,
  output logic [AW-1:0]     fwr_addr,
  output logic [DATA_W-1:0] fwr_data,
  output logic              fill_busy
);
  fill_st_t          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ins_q, reg_q, alloc_q, way_q;
  logic [OFF_W-1:0]  beat_q;
  logic [DATA_W-1:0] word_q;
  logic              alloc_now, victim, last_beat, beat_is_req, beat_in;

  assign req_ready   = (st_q == ST_IDLE);
  assign fill_busy   = (st_q != ST_IDLE);
  assign req_fire    = req_valid && req_ready;
  assign lookup_hit  = req_fire && !ram_active && (|lk_hit);
  assign hit_way     = lk_hit[1];
  assign alloc_now   = !ram_active && !upd_lock;
  assign victim      = pick_victim(lk_vld[0], lk_vld[1], lk_mru);
  assign last_beat   = (beat_q == OFF_W'(WORDS - 1));
  assign beat_is_req = (beat_q == addr_q[OFF_W-1:0]);
  assign beat_in     = (st_q == ST_WAIT) && mem_rvalid;

  assign fill_start = req_fire && !lookup_hit && alloc_now;
  assign fill_end   = beat_in && last_beat && alloc_q;
  assign fill_way   = (st_q == ST_IDLE) ? victim : way_q;
  assign fill_idx   = (st_q == ST_IDLE) ? req_addr[OFF_W +: IDX_W] : addr_q[OFF_W +: IDX_W];
  assign fill_tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign fwr_en     = beat_in && alloc_q;
  assign fwr_addr   = {way_q, addr_q[OFF_W +: IDX_W], beat_q};
  assign fwr_data   = mem_rdata;

  assign mem_req    = (st_q == ST_REQ);
  assign mem_addr   = {addr_q[ADDR_W-1:OFF_W], beat_q};
  assign mem_instr  = ins_q;
  assign mem_region = reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      ins_q     <= 1'b0;
      reg_q     <= 1'b0;
      alloc_q   <= 1'b0;
      way_q     <= 1'b0;
      beat_q    <= '0;
      word_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (lookup_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_data  <= hit_rdata;
          end else if (req_fire) begin
            st_q    <= ST_REQ;
            addr_q  <= req_addr;
            ins_q   <= req_instr;
            reg_q   <= req_region;
            alloc_q <= alloc_now;
            way_q   <= victim;
            beat_q  <= '0;
          end
        end
        ST_REQ: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid) begin
            if (beat_is_req) word_q <= mem_rdata;
            if (last_beat) begin
              st_q      <= ST_IDLE;
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              rsp_data  <= beat_is_req ? mem_rdata : word_q;
            end else begin
              beat_q <= beat_q + OFF_W'(1);
              st_q   <= ST_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_read_cache.sv
module sa_read_cache
  import sarc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int AW    = 1 + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_instr,
  input  logic              req_region,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_instr,
  output logic              mem_region,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_upd_lock,
  input  logic              cfg_ram_mode,
  input  logic              cfg_rd_lock,
  input  logic              ram_en,
  input  logic              ram_we,
  input  logic [AW-1:0]     ram_addr,
  input  logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] ram_rdata,
  input  logic [IDX_W-1:0]  dbg_set,
  input  logic              dbg_way,
  output logic [TAG_W-1:0]  dbg_tag,
  output logic              dbg_valid,
  output logic              dbg_mru
);
  logic              ram_q, rd_lock_q, ram_enter, ram_exit;
  logic [WAYS-1:0]   lk_hit, lk_vld;
  logic              lk_mru, any_valid;
  logic              req_fire, lookup_hit, hit_way;
  logic              fill_start, fill_end, fill_way, fill_busy, tag_we;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic              fwr_en, ram_wr, ram_rd;
  logic [AW-1:0]     fwr_addr, d_waddr, d_raddr;
  logic [DATA_W-1:0] fwr_data, d_wdata, d_rdata;

  assign ram_enter = cfg_ram_mode && !ram_q;
  assign ram_exit  = !cfg_ram_mode && ram_q;
  assign ram_wr    = ram_q && ram_en && ram_we;
  assign ram_rd    = ram_q && ram_en && !ram_we;
  assign tag_we    = fill_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_q     <= 1'b0;
      rd_lock_q <= 1'b0;
      ram_rdata <= '0;
    end else begin
      ram_q     <= cfg_ram_mode;
      rd_lock_q <= rd_lock_q | cfg_rd_lock;
      ram_rdata <= ram_rd ? d_rdata : '0;
    end
  end

  // Fill writes and RAM-port writes never coincide: fills do not allocate in RAM mode.
  assign d_waddr = fwr_en ? fwr_addr : ram_addr;
  assign d_wdata = fwr_en ? fwr_data : ram_wdata;
  assign d_raddr = ram_q ? ram_addr : {hit_way, req_addr[OFF_W +: IDX_W], req_addr[OFF_W-1:0]};

  sarc_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_instr(req_instr), .req_region(req_region),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_instr(mem_instr), .mem_region(mem_region),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ram_active(ram_q), .upd_lock(cfg_upd_lock),
    .lk_hit(lk_hit), .lk_vld(lk_vld), .lk_mru(lk_mru), .hit_rdata(d_rdata),
    .req_fire(req_fire), .lookup_hit(lookup_hit), .hit_way(hit_way),
    .fill_start(fill_start), .fill_end(fill_end), .fill_way(fill_way),
    .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fwr_en(fwr_en), .fwr_addr(fwr_addr), .fwr_data(fwr_data), .fill_busy(fill_busy)
  );

  sarc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_addr[OFF_W +: IDX_W]), .lk_tag(req_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit(lk_hit), .lk_vld(lk_vld), .lk_mru(lk_mru),
    .fill_start(fill_start), .fill_end(fill_end),
    .wr_idx(fill_idx), .wr_way(fill_way), .wr_tag(fill_tag),
    .touch(lookup_hit), .touch_way(hit_way), .inv_all(ram_exit),
    .dbg_idx(dbg_set), .dbg_way(dbg_way), .dbg_hide(rd_lock_q && !ram_q),
    .dbg_tag(dbg_tag), .dbg_valid(dbg_valid), .dbg_mru(dbg_mru), .any_valid(any_valid)
  );

  sarc_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .clr_all(ram_enter),
    .we(fwr_en || ram_wr), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic mem_req,
  input logic mem_rvalid,
  input logic lookup_hit,
  input logic tag_we,
  input logic ram_q,
  input logic ram_exit,
  input logic any_valid,
  input logic rd_lock_q,
  input logic fill_busy
);
  // R1
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (rsp_valid && rsp_hit));

  // R2
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || fill_busy) |-> !req_ready);

  // R2
  miss_resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> $past(mem_rvalid));

  // R7
  ram_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_q |-> !tag_we);

  // R9
  ram_exit_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_exit |=> !any_valid);

  // R6
  rd_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lock_q |=> rd_lock_q);
endmodule

bind sa_read_cache sarc_chk u_sarc_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .lookup_hit(lookup_hit), .tag_we(tag_we), .ram_q(ram_q), .ram_exit(ram_exit),
  .any_valid(any_valid), .rd_lock_q(rd_lock_q), .fill_busy(fill_busy)
);

// File: tb/test_sa_read_cache.sv
`timescale 1ns/1ps
module test_sa_read_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_instr = 1'b0, req_region = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        mem_req, mem_instr, mem_region;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        cfg_upd_lock = 1'b0, cfg_ram_mode = 1'b0, cfg_rd_lock = 1'b0;
  logic        ram_en = 1'b0, ram_we = 1'b0;
  logic [5:0]  ram_addr = '0;
  logic [31:0] ram_wdata = '0, ram_rdata;
  logic [2:0]  dbg_set = '0;
  logic        dbg_way = 1'b0;
  logic [10:0] dbg_tag;
  logic        dbg_valid, dbg_mru;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0, beats_total = 0;
  logic [15:0] salt = '0;
  logic [15:0] cur_addr = '0;
  logic        cur_instr = 1'b0, cur_region = 1'b0;
  int          beat_idx = 0;

  always #4 clk = ~clk;

  sa_read_cache i_sa_read_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_instr(req_instr), .req_region(req_region),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_instr(mem_instr), .mem_region(mem_region),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cfg_upd_lock(cfg_upd_lock), .cfg_ram_mode(cfg_ram_mode), .cfg_rd_lock(cfg_rd_lock),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .dbg_set(dbg_set), .dbg_way(dbg_way),
    .dbg_tag(dbg_tag), .dbg_valid(dbg_valid), .dbg_mru(dbg_mru)
  );

  function automatic logic [31:0] mem_word(input logic [15:0] a, input logic [15:0] s);
    return {a ^ s, ~a};
  endfunction

  // Registered backing-memory stub: data one cycle after the beat request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem_word(mem_addr, salt);
    end
  end

  // Beat monitor: R2 order and R13 flags.
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      mon_checks++;
      if (mem_addr !== {cur_addr[15:2], beat_idx[1:0]} || mem_instr !== cur_instr ||
          mem_region !== cur_region) begin
        mon_errors++;
        $display("FAIL R2/R13 beat act=%h/%b/%b exp=%h/%b/%b", mem_addr, mem_instr, mem_region,
                 {cur_addr[15:2], beat_idx[1:0]}, cur_instr, cur_region);
      end
      beat_idx    = beat_idx + 1;
      beats_total = beats_total + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] a, input logic ins, input logic rg,
                       output logic [31:0] d, output logic h, output int beats, output int lat);
    int start;
    @(negedge clk);
    cur_addr = a; cur_instr = ins; cur_region = rg; beat_idx = 0;
    start = beats_total;
    req_valid = 1'b1; req_addr = a; req_instr = ins; req_region = rg;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 80) begin
      @(negedge clk);
      lat++;
    end
    if (lat >= 80) chk("R2 response timeout", 32'(lat), 32'd0);
    d = rsp_data; h = rsp_hit; beats = beats_total - start;
  endtask

  task automatic dchk(input logic [2:0] s, input logic w, input logic [10:0] et,
                      input logic ev, input logic em, input string r);
    @(negedge clk);
    dbg_set = s; dbg_way = w;
    #1;
    chk({r, " dbg_tag"}, 32'(dbg_tag), 32'(et));
    chk({r, " dbg_valid"}, 32'(dbg_valid), 32'(ev));
    chk({r, " dbg_mru"}, 32'(dbg_mru), 32'(em));
  endtask

  task automatic ram_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    ram_en = 1'b1; ram_we = 1'b1; ram_addr = a; ram_wdata = d;
    @(negedge clk);
    ram_en = 1'b0; ram_we = 1'b0;
  endtask

  task automatic ram_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    ram_en = 1'b1; ram_we = 1'b0; ram_addr = a;
    @(negedge clk);
    ram_en = 1'b0;
    d = ram_rdata;
  endtask

  task automatic fcheck(input logic [15:0] a, input logic exp_hit, input logic [15:0] s,
                        input string r);
    logic [31:0] d; logic h; int b, l;
    fetch(a, 1'b0, 1'b1, d, h, b, l);
    chk({r, " data"}, d, mem_word(a, s));
    chk({r, " hit"}, 32'(h), 32'(exp_hit));
    chk({r, " beats"}, 32'(b), exp_hit ? 32'd0 : 32'd4);
    if (exp_hit) chk({r, " hit latency"}, 32'(l), 32'd0);
  endtask

  // {expected hit, instr flag, region flag, word address}; tag = addr[15:5], set = addr[4:2]
  localparam logic [18:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b0, 16'h0022},  // t1 s0: miss, way0
    {1'b1, 1'b0, 1'b1, 16'h0020},  // t1 hit
    {1'b0, 1'b0, 1'b0, 16'h0043},  // t2 miss, way1 (invalid first)
    {1'b1, 1'b1, 1'b1, 16'h0021},  // t1 hit, MRU -> way0
    {1'b0, 1'b1, 1'b1, 16'h0060},  // t3 miss, evicts way1 (non-MRU)
    {1'b1, 1'b0, 1'b0, 16'h0023},  // t1 hit, MRU -> way0
    {1'b0, 1'b0, 1'b1, 16'h0040},  // t2 miss, evicts way1
    {1'b0, 1'b1, 1'b0, 16'h0061},  // t3 miss, evicts way0
    {1'b0, 1'b0, 1'b1, 16'h00AD},  // t5 s3 miss
    {1'b1, 1'b1, 1'b1, 16'h00AD}   // t5 hit
  };

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  initial begin
    logic [31:0] d; logic h; int b, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 req_ready", 32'(req_ready), 32'd1);
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R12 mem_req", 32'(mem_req), 32'd0);
    dchk(3'd0, 1'b0, 11'd0, 1'b0, 1'b0, "R12 s0w0");
    dchk(3'd3, 1'b1, 11'd0, 1'b0, 1'b0, "R12 s3w1");

    // R1 R2 R3 R4 R13 table walk
    for (int i = 0; i < 10; i++) begin
      fetch(VEC[i][15:0], VEC[i][17], VEC[i][16], d, h, b, l);
      chk($sformatf("R1/R2 vec%0d data", i), d, mem_word(VEC[i][15:0], 16'h0));
      chk($sformatf("R1/R2 vec%0d hit", i), 32'(h), 32'(VEC[i][18]));
      chk($sformatf("R1/R2 vec%0d beats", i), 32'(b), VEC[i][18] ? 32'd0 : 32'd4);
      if (VEC[i][18]) chk($sformatf("R1 vec%0d latency", i), 32'(l), 32'd0);
    end
    // R4 R3: replacement outcome visible through debug
    dchk(3'd0, 1'b0, 11'd3, 1'b1, 1'b0, "R4 s0w0");
    dchk(3'd0, 1'b1, 11'd2, 1'b1, 1'b0, "R4 s0w1");
    dchk(3'd3, 1'b0, 11'd5, 1'b1, 1'b0, "R3 s3w0");
    dchk(3'd3, 1'b1, 11'd0, 1'b0, 1'b0, "R4 s3w1");

    // R5 update lock with changed memory contents
    salt = 16'h00F0;
    cfg_upd_lock = 1'b1;
    fcheck(16'h00E4, 1'b0, salt, "R5 locked miss");
    dchk(3'd1, 1'b0, 11'd0, 1'b0, 1'b0, "R5 no alloc w0");
    dchk(3'd1, 1'b1, 11'd0, 1'b0, 1'b0, "R5 no alloc w1");
    fcheck(16'h00E4, 1'b0, salt, "R5 repeat miss");
    fcheck(16'h0062, 1'b1, 16'h0, "R5 old hit");
    fcheck(16'h0041, 1'b1, 16'h0, "R5 old hit way1");
    dchk(3'd0, 1'b1, 11'd2, 1'b1, 1'b1, "R3 hit MRU");
    cfg_upd_lock = 1'b0;

    // R6 read lock
    @(negedge clk); cfg_rd_lock = 1'b1;
    @(negedge clk); cfg_rd_lock = 1'b0;
    dchk(3'd0, 1'b1, 11'd0, 1'b0, 1'b0, "R6 hidden");

    // R7 R8 R10 RAM mode
    @(negedge clk); cfg_ram_mode = 1'b1;
    repeat (2) @(negedge clk);
    dchk(3'd0, 1'b1, 11'd2, 1'b1, 1'b1, "R10 visible in RAM mode");
    ram_rd(6'h01, d); chk("R8 cleared w0", d, 32'h0);
    ram_rd(6'h21, d); chk("R8 cleared w1", d, 32'h0);
    ram_wr(6'h2B, 32'hCAFE_F00D);
    ram_rd(6'h2B, d); chk("R7 ram readback", d, 32'hCAFE_F00D);
    fcheck(16'h0041, 1'b0, salt, "R7 uncached fetch");
    dchk(3'd0, 1'b1, 11'd2, 1'b1, 1'b1, "R7 no alloc");

    // R9 exit invalidates (read lock hides debug, observe via fetch)
    @(negedge clk); cfg_ram_mode = 1'b0;
    repeat (2) @(negedge clk);
    fcheck(16'h0062, 1'b0, salt, "R9 invalid after exit");
    fcheck(16'h0041, 1'b0, salt, "R9 invalid after exit way1");

    // R11 RAM port ignored outside RAM mode
    ram_wr(6'h01, 32'hDEAD_0000);
    ram_rd(6'h01, d); chk("R11 rdata zero", d, 32'h0);
    fcheck(16'h0061, 1'b1, salt, "R11 cached word intact");

    // R6 only reset clears the lock
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    dchk(3'd0, 1'b0, 11'd0, 1'b0, 1'b0, "R12 after reset");
    fcheck(16'h0061, 1'b0, salt, "R12 miss after reset");
    dchk(3'd0, 1'b0, 11'd3, 1'b1, 1'b0, "R6 lock cleared");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule